// File: doc/BRIEF.md
# Sampling Converter Serial Control with Power Modes

This block is the digital control of a serial sampling converter. A rising edge on the convert-start pin captures a new sample from `sample_i`. This input stands in for the analog path. The same edge also starts a new output frame. Each rising edge of the serial clock moves the frame on by one bit. The word sent in a frame is always the sample taken at the previous convert-start, so a host reads result N-1 while conversion N runs.

The data line is modelled as a data bit with a separate drive enable, and it is driven only during a frame. Power saving is controlled with the same two pins. The host pulses convert-start while holding the serial clock still. Exactly two such pulses, followed by a quiet window, put the block into nap. Four or more pulses put it into sleep. A serial clock rising edge wakes the block from either mode. A convert-start edge also ends nap, but it is ignored in sleep.

Both pins are sampled on the system clock `clk`, which runs much faster than the serial clock.

Top module: `adc_serial_ctl`

## Requirements
- R1: After reset, `mode_o` is 00, `sdo_oe_o` is 0, and both stored result words are zero.
- R2: In active mode, a convert-start rising edge captures `sample_i` and raises `sdo_oe_o` from the next system clock.
- R3: A frame is 16 serial clock rising edges long. Bit positions 0 and 1 are zero. Positions 2 to RES_W+1 carry the result MSB first. Any later positions are zero.
- R4: The word sent in a frame is the sample captured at the previous convert-start. The first frame after reset sends zero.
- R5: `sdo_oe_o` falls after the 16th serial clock rising edge of a frame. `sdo_o` is 0 whenever `sdo_oe_o` is 0.
- R6: Exactly two convert-start rising edges with no serial clock edge between them, followed by TIMEOUT quiet system clocks, set `mode_o` to 01 (nap).
- R7: Four or more such edges set `mode_o` to 10 (sleep). Three edges leave the mode at 00. The pulse count saturates at four.
- R8: Any serial clock edge, rising or falling, clears the pulse count, so pulses separated by serial clock activity do not add up.
- R9: A serial clock rising edge in nap or sleep returns `mode_o` to 00.
- R10: In sleep, a convert-start edge is ignored. No frame starts and the stored sample is kept. `sdo_oe_o` stays 0 for the whole time in sleep.
- R11: In nap, a convert-start edge returns `mode_o` to 00 without capturing a sample or starting a frame. The next edge starts a normal frame.
- R12: `mode_o` never shows the unused code 11.
- R13: RES_W selects a 12-bit or 14-bit result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_i | input | 1 | Convert-start pin |
| sck_i | input | 1 | Serial clock pin |
| sample_i | input | RES_W | Sample value captured on convert-start |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Drive enable for the serial data line (0 = high impedance) |
| mode_o | output | 2 | Power mode: 00 active, 01 nap, 10 sleep |

## Verification
The bench builds the block with RES_W = 12 and TIMEOUT = 8. The 12-bit width leaves two padding positions at the end of each frame, so the trailing-zero part of R3 can be checked. The short timeout means every nap and sleep decision, and the three-pulse case that must not change the mode, completes in a few dozen cycles. This leaves room to chain the entry into each mode, both ways of waking from it, and the stored-word checks across each transition in one run.

// File: rtl/adc_serial_pkg.sv
package adc_serial_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'b00,
    PM_NAP    = 2'b01,
    PM_SLEEP  = 2'b10
  } pmode_t;

  localparam int FRAME_LEN = 16;

  function automatic logic [15:0] build_frame(input logic [13:0] aligned);
    return {2'b00, aligned};
  endfunction

  function automatic logic pick_bit(input logic [15:0] frame, input logic [3:0] pos);
    return frame[4'd15 - pos];
  endfunction

  function automatic logic [2:0] sat_inc(input logic [2:0] n);
    return (n >= 3'd4) ? 3'd4 : n + 3'd1;
  endfunction
endpackage

// File: rtl/pin_sampler.sv
module pin_sampler #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins_i,
  output logic [N-1:0] prev_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_o[g] <= 1'b0;
      else        prev_o[g] <= pins_i[g];
    end
  end
endmodule

// File: rtl/power_ctl.sv
module power_ctl
  import adc_serial_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   conv_rise,
  input  logic   sck_rise,
  input  logic   sck_edge,
  output pmode_t mode_o,
  output logic   start_o,
  output logic   drop_o
);
  localparam int IDLE_W = $clog2(TIMEOUT + 1);

  logic [2:0]        pcnt_q;
  logic [IDLE_W-1:0] idle_q;
  logic              decide_w, nap_go, sleep_go;

  assign decide_w = (mode_o == PM_ACTIVE) && !sck_edge && !conv_rise &&
                    (pcnt_q >= 3'd2) && (idle_q == IDLE_W'(TIMEOUT - 1));
  assign nap_go   = decide_w && (pcnt_q == 3'd2);
  assign sleep_go = decide_w && (pcnt_q == 3'd4);
  assign start_o  = conv_rise && (mode_o == PM_ACTIVE);
  assign drop_o   = nap_go || sleep_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o <= PM_ACTIVE;
      pcnt_q <= '0;
      idle_q <= '0;
    end else begin
      case (mode_o)
        PM_ACTIVE: begin
          if (sck_edge) begin
            pcnt_q <= '0;
            idle_q <= '0;
          end else if (conv_rise) begin
            pcnt_q <= sat_inc(pcnt_q);
            idle_q <= '0;
          end else if (decide_w) begin
            pcnt_q <= '0;
            idle_q <= '0;
            if (nap_go)        mode_o <= PM_NAP;
            else if (sleep_go) mode_o <= PM_SLEEP;
          end else if (pcnt_q >= 3'd2) begin
            idle_q <= idle_q + 1'b1;
          end
        end
        PM_NAP: if (sck_rise || conv_rise) mode_o <= PM_ACTIVE;
        PM_SLEEP: if (sck_rise) mode_o <= PM_ACTIVE;
        default: mode_o <= PM_ACTIVE;
      endcase
    end
  end

  AST_PCNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= 3'd4);  // R7
  AST_NAP_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_NAP && conv_rise) |=> mode_o == PM_ACTIVE);  // R11
  AST_WAKE_SCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != PM_ACTIVE && sck_rise) |=> mode_o == PM_ACTIVE);  // R9
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_SLEEP && conv_rise && !sck_rise) |=> mode_o == PM_SLEEP);  // R10
  AST_MODE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'b11);  // R12
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import adc_serial_pkg::*;
#(
  parameter int RES_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             sck_rise,
  input  logic             drop_i,
  input  logic [RES_W-1:0] sample_i,
  output logic             sdo_o,
  output logic             sdo_oe_o
);
  localparam int PAD = 14 - RES_W;

  logic [RES_W-1:0] cur_q, out_q;
  logic [3:0]       pos_q;
  logic             busy_q;
  logic [15:0]      frame_w;
  logic             last_bit_w;

  assign frame_w    = build_frame(14'(out_q) << PAD);
  assign last_bit_w = busy_q && sck_rise && (pos_q == 4'(FRAME_LEN - 1));
  assign sdo_oe_o   = busy_q;
  assign sdo_o      = busy_q && pick_bit(frame_w, pos_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      out_q  <= '0;
      pos_q  <= '0;
      busy_q <= 1'b0;
    end else if (drop_i) begin
      busy_q <= 1'b0;
    end else if (start_i) begin
      out_q  <= cur_q;
      cur_q  <= sample_i;
      pos_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q && sck_rise) begin
      pos_q <= pos_q + 1'b1;
      if (last_bit_w) busy_q <= 1'b0;
    end
  end

  AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe_o && pos_q < 4'd2) |-> !sdo_o);  // R3
  AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    (last_bit_w && !start_i) |=> !sdo_oe_o);  // R5
  AST_START_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !drop_i) |=> sdo_oe_o);  // R2
endmodule

// File: rtl/adc_serial_ctl.sv
module adc_serial_ctl
  import adc_serial_pkg::*;
#(
  parameter int RES_W   = 14,
  parameter int TIMEOUT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_i,
  input  logic             sck_i,
  input  logic [RES_W-1:0] sample_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic [1:0]       mode_o
);
  logic [1:0] prev_w;
  logic       conv_rise, sck_rise, sck_edge;
  logic       start_w, drop_w;
  pmode_t     mode_w;

  pin_sampler #(.N(2)) u_pins (
    .clk(clk), .rst_n(rst_n), .pins_i({sck_i, conv_i}), .prev_o(prev_w)
  );

  assign conv_rise = conv_i & ~prev_w[0];
  assign sck_rise  = sck_i & ~prev_w[1];
  assign sck_edge  = sck_i ^ prev_w[1];

  power_ctl #(.TIMEOUT(TIMEOUT)) u_pwr (
    .clk(clk), .rst_n(rst_n), .conv_rise(conv_rise), .sck_rise(sck_rise),
    .sck_edge(sck_edge), .mode_o(mode_w), .start_o(start_w), .drop_o(drop_w)
  );

  frame_shifter #(.RES_W(RES_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start_i(start_w), .sck_rise(sck_rise),
    .drop_i(drop_w), .sample_i(sample_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
  );

  assign mode_o = mode_w;

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_SLEEP) |-> !sdo_oe_o);  // R10
  AST_NAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_NAP) |-> !sdo_oe_o);  // R6
endmodule

// File: tb/test_adc_serial_ctl.sv
module test_adc_serial_ctl;
  localparam int W  = 12;
  localparam int TO = 8;
  localparam logic [W-1:0] VEC [8] = '{12'hA5C, 12'h001, 12'hFFF, 12'h800,
                                       12'h3C3, 12'h555, 12'hAAA, 12'h7FE};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         conv = 1'b0;
  logic         sck = 1'b0;
  logic [W-1:0] sample = '0;
  logic         sdo, sdo_oe;
  logic [1:0]   mode;
  int           checks = 0;
  int           errors = 0;
  logic [W-1:0] held = '0;
  logic [15:0]  got;
  logic         oe_ok;

  always #5 clk = ~clk;

  adc_serial_ctl #(.RES_W(W), .TIMEOUT(TO)) i_adc_serial_ctl (
    .clk(clk), .rst_n(rst_n), .conv_i(conv), .sck_i(sck), .sample_i(sample),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .mode_o(mode)
  );

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic conv_pulse(input logic [W-1:0] v);
    sample = v; conv = 1'b1; tick(); conv = 1'b0; tick();
  endtask

  task automatic sck_pulse();
    sck = 1'b1; tick(); sck = 1'b0; tick();
  endtask

  task automatic read_frame();
    oe_ok = 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (sdo_oe !== 1'b1) oe_ok = 1'b0;
      got[15-i] = sdo;
      sck_pulse();
    end
  endtask

  function automatic logic [15:0] exp_frame(input logic [W-1:0] v);
    return 16'(v) << (14 - W);
  endfunction

  task automatic frame_check(input string req, input logic [W-1:0] v);
    read_frame();
    chk({req, " frame oe"}, oe_ok, 1'b1);
    chk({req, " frame word"}, got, exp_frame(v));
    chk("R5 oe low after frame", {sdo_oe, sdo}, 2'b00);
  endtask

  task automatic quiet(); repeat (TO + 4) tick(); endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R1 reset mode", mode, 2'b00);
    chk("R1 reset oe", sdo_oe, 1'b0);
    rst_n = 1'b1;
    tick();

    // R2 R3 R4 R13: vector walk, each frame carries the previous sample
    for (int k = 0; k < 8; k++) begin
      sample = VEC[k]; conv = 1'b1; tick();
      chk("R2 oe after convert", sdo_oe, 1'b1);
      conv = 1'b0; tick();
      frame_check("R4 R3 R13", held);
      held = VEC[k];
    end

    // R6 R11: two pulses give nap; convert in nap only resumes
    conv_pulse(12'h111); conv_pulse(12'h222); held = 12'h222;
    quiet();
    chk("R6 nap mode", mode, 2'b01);
    chk("R6 nap quiet", sdo_oe, 1'b0);
    conv_pulse(12'h333);
    chk("R11 resume mode", mode, 2'b00);
    chk("R11 no frame", sdo_oe, 1'b0);
    conv_pulse(12'h444);
    frame_check("R11", held); held = 12'h444;

    // R7: three pulses keep active
    conv_pulse(12'h0F0); conv_pulse(12'h0E0); conv_pulse(12'h0D0);
    quiet();
    chk("R7 three pulses mode", mode, 2'b00);
    frame_check("R7 three", 12'h0E0); held = 12'h0D0;

    // R8: serial clock between pulses breaks the pattern
    conv_pulse(12'h123); sck_pulse(); conv_pulse(12'h456);
    quiet();
    chk("R8 mode stays", mode, 2'b00);
    frame_check("R8", 12'h123); held = 12'h456;

    // R7 R10 R9: five pulses give sleep, convert ignored, sck wakes
    conv_pulse(12'hC01); conv_pulse(12'hC02); conv_pulse(12'hC03);
    conv_pulse(12'hC04); conv_pulse(12'hC05); held = 12'hC05;
    quiet();
    chk("R7 sleep mode", mode, 2'b10);
    chk("R10 sleep quiet", sdo_oe, 1'b0);
    conv_pulse(12'hBAD);
    chk("R10 convert ignored mode", mode, 2'b10);
    chk("R10 convert ignored oe", sdo_oe, 1'b0);
    sck_pulse();
    chk("R9 sleep wake", mode, 2'b00);
    conv_pulse(12'h9A9);
    frame_check("R10 kept sample", held); held = 12'h9A9;

    // R9: sck wakes from nap
    conv_pulse(12'h6B6); conv_pulse(12'h7C7); held = 12'h7C7;
    quiet();
    chk("R6 nap again", mode, 2'b01);
    sck_pulse();
    chk("R9 nap wake", mode, 2'b00);
    conv_pulse(12'h010);
    frame_check("R9", held);
    chk("R12 mode code", mode, 2'b00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule